// File: doc/BRIEF.md
# Opmask AND-NOT Execute Unit

This block decodes and executes the register-only mask AND-NOT instruction against a private file of eight 64-bit mask registers. Earlier pipeline stages hand it several fields that are already extracted: the vector-length bit, a two-bit implied-prefix selector, the W bit, the inverted four-bit source specifier, the opcode byte and the ModRM byte. In a single cycle the block reads two mask registers and forms the complement of the first source ANDed with the second. The operand width of 8, 16, 32 or 64 bits comes from W and the prefix selector. Every bit above that width is cleared, and the result is written to the destination register on the next clock edge.

Any illegal encoding raises an invalid-opcode fault and blocks the write. No flags or exception state other than this fault exist. A combinational observation port returns any mask entry, so the surrounding logic and the bench can see the file. After reset, each entry holds a fixed pattern derived from a seed parameter, so the file never starts out all zero.

Top module: `mask_andn_unit`

## Requirements
- R1: After synchronous active-low reset, mask entry i (0..7) holds the SEED parameter rotated left by 8*i bits.
- R2: An operation is legal when valid_i=1, opc_i=8'h42, len_i=1, modrm_i[7:6]=2'b11, pfx_i is 2'b00 (none) or 2'b01 (66), and vvvv_n_i[3]=1. A legal operation keeps fault_o low and writes the destination.
- R3: The operand width N depends on w_i and pfx_i. w_i=0 with 2'b00 gives 16, w_i=0 with 2'b01 gives 8, w_i=1 with 2'b00 gives 64, and w_i=1 with 2'b01 gives 32.
- R4: res_o equals (NOT src1) AND src2 over bits N-1:0. Here src1 is entry ~vvvv_n_i[2:0], src2 is entry modrm_i[2:0], and the destination is entry modrm_i[5:3].
- R5: Bits 63:N of res_o and of the written destination are 0.
- R6: If modrm_i[7:6] is not 2'b11 while valid_i=1, fault_o is 1 and no entry changes.
- R7: While valid_i=1, each of these raises fault_o and suppresses the write: len_i=0, opc_i other than 8'h42, pfx_i of 2'b10 or 2'b11, or vvvv_n_i[3]=0.
- R8: While valid_i=0, fault_o is 0 and no entry changes, whatever the other fields hold.
- R9: A legal result appears in the destination one clock edge after issue. When the destination is also a source, the computation uses the old source value.
- R10: rd_data_o shows entry rd_idx_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| len_i | input | 1 | Vector-length bit |
| pfx_i | input | 2 | Implied prefix: 00 none, 01 66, 10 F3, 11 F2 |
| w_i | input | 1 | W bit |
| vvvv_n_i | input | 4 | Inverted first-source specifier |
| opc_i | input | 8 | Opcode byte |
| modrm_i | input | 8 | ModRM byte: mode, destination, second source |
| rd_idx_i | input | 3 | Observation port index |
| fault_o | output | 1 | Invalid-opcode fault |
| res_o | output | 64 | Computed result for the current operation |
| rd_data_o | output | 64 | Observed mask entry |

## Verification
The bench keeps NUM_REGS at eight and the mask width at 64. It overrides SEED with 64'hF0E1D2C3B4A59687, a pattern whose bytes are all different, so each rotated reset entry is distinct. That makes a swapped source, a wrong destination index or a misplaced width boundary visible in the results. Because the pattern has both set and clear bits in every byte, the AND-NOT result is non-trivial at all four widths, and a stray write to a faulting destination would leave a visible change.

// File: rtl/mask_andn_pkg.sv
// Package: shared encodings for the opmask AND-NOT unit.
// Assumes the mask file is 64 bits wide and the width codes are ordered 8..64.
package mask_andn_pkg;
    localparam logic [7:0] OPC_ANDN = 8'h42;

    typedef enum logic [1:0] {
        PFX_NONE = 2'b00,
        PFX_66   = 2'b01,
        PFX_F3   = 2'b10,
        PFX_F2   = 2'b11
    } pfx_e;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2,
        WID_64 = 2'd3
    } wid_e;
endpackage

// File: rtl/mask_andn_decode.sv
// Decoder: checks the instruction fields, picks the operand width and
// extracts the three register indices. Purely combinational.
// Assumes the index fields are already 3 bits (no register extension).
module mask_andn_decode
    import mask_andn_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             valid_i,
    input  logic             len_i,
    input  logic [1:0]       pfx_i,
    input  logic             w_i,
    input  logic [3:0]       vvvv_n_i,
    input  logic [7:0]       opc_i,
    input  logic [7:0]       modrm_i,
    output logic             legal_o,
    output logic             fault_o,
    output wid_e             wid_o,
    output logic [IDX_W-1:0] src1_o,
    output logic [IDX_W-1:0] src2_o,
    output logic [IDX_W-1:0] dst_o
);
    logic opc_ok, mode_ok, pfx_ok, spec_ok;

    // Field legality checks.
    always_comb begin
        opc_ok  = (opc_i == OPC_ANDN);
        mode_ok = (modrm_i[7:6] == 2'b11);
        pfx_ok  = (pfx_i == PFX_NONE) || (pfx_i == PFX_66);
        spec_ok = vvvv_n_i[3];
        legal_o = valid_i && len_i && opc_ok && mode_ok && pfx_ok && spec_ok;
        fault_o = valid_i && !legal_o;
    end

    // Width selection from W and the prefix selector.
    always_comb begin
        unique case ({w_i, pfx_i[0]})
            2'b00:   wid_o = WID_16;
            2'b01:   wid_o = WID_8;
            2'b10:   wid_o = WID_64;
            default: wid_o = WID_32;
        endcase
    end

    // Register index extraction; the first source is stored inverted.
    always_comb begin
        src1_o = IDX_W'(~vvvv_n_i[2:0]);
        src2_o = IDX_W'(modrm_i[2:0]);
        dst_o  = IDX_W'(modrm_i[5:3]);
    end
endmodule

// File: rtl/mask_andn_alu.sv
// Datapath: (NOT a) AND b, cut to the selected width, upper bits cleared.
// One candidate per width is built in a generate loop and selected by code.
// Assumes MASK_W is 64 so the four widths 8..64 all fit.
module mask_andn_alu
    import mask_andn_pkg::*;
#(
    parameter int MASK_W = 64
) (
    input  logic [MASK_W-1:0] a_i,
    input  logic [MASK_W-1:0] b_i,
    input  wid_e              wid_i,
    output logic [MASK_W-1:0] res_o
);
    localparam int NUM_WID = 4;

    logic [MASK_W-1:0] raw;
    logic [MASK_W-1:0] cand [NUM_WID];

    // Full-width AND-NOT before trimming.
    always_comb raw = (~a_i) & b_i;

    for (genvar g = 0; g < NUM_WID; g++) begin : g_lane
        localparam int LW = 8 << g;
        localparam logic [MASK_W-1:0] LMASK =
            (LW >= MASK_W) ? {MASK_W{1'b1}} : ((MASK_W'(1) << LW) - MASK_W'(1));
        // Trim the raw result to this lane's width.
        always_comb cand[g] = raw & LMASK;
    end

    // Pick the lane for the decoded width.
    always_comb res_o = cand[wid_i];
endmodule

// File: rtl/mask_andn_regfile.sv
// Mask register file: two combinational source reads, one observation read,
// one synchronous write. Entries reset to a seed rotated by 8*i bits.
// Assumes a single write per cycle.
module mask_andn_regfile #(
    parameter int              MASK_W   = 64,
    parameter int              NUM_REGS = 8,
    parameter logic [MASK_W-1:0] SEED   = 64'h0123_4567_89AB_CDEF,
    localparam int             IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [IDX_W-1:0]           waddr_i,
    input  logic [MASK_W-1:0]          wdata_i,
    input  logic [IDX_W-1:0]           ra1_i,
    input  logic [IDX_W-1:0]           ra2_i,
    input  logic [IDX_W-1:0]           ra3_i,
    output logic [MASK_W-1:0]          rd1_o,
    output logic [MASK_W-1:0]          rd2_o,
    output logic [MASK_W-1:0]          rd3_o,
    output logic [NUM_REGS*MASK_W-1:0] all_o
);
    logic [MASK_W-1:0] ent [NUM_REGS];

    function automatic logic [MASK_W-1:0] rotl(input logic [MASK_W-1:0] x, input int s);
        int k;
        k = s % MASK_W;
        return (k == 0) ? x : ((x << k) | (x >> (MASK_W - k)));
    endfunction

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
        localparam logic [MASK_W-1:0] RST_VAL = rotl(SEED, 8 * i);
        // Hold, reset or overwrite entry i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[i] <= RST_VAL;
            else if (we_i && (waddr_i == IDX_W'(i)))
                ent[i] <= wdata_i;
        end
        // Flatten entry i for observation.
        always_comb all_o[i*MASK_W +: MASK_W] = ent[i];
    end

    // Combinational read ports.
    always_comb begin
        rd1_o = ent[ra1_i];
        rd2_o = ent[ra2_i];
        rd3_o = ent[ra3_i];
    end
endmodule

// File: rtl/mask_andn_unit.sv
// Top: opmask AND-NOT execute unit. Decodes the fields, reads two sources,
// computes the trimmed AND-NOT and writes it back on the next edge unless
// the encoding faults. Assumes one operation per cycle with no stalls.
module mask_andn_unit
    import mask_andn_pkg::*;
#(
    parameter int          MASK_W   = 64,
    parameter int          NUM_REGS = 8,
    parameter logic [63:0] SEED     = 64'h0123_4567_89AB_CDEF,
    localparam int         IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              len_i,
    input  logic [1:0]        pfx_i,
    input  logic              w_i,
    input  logic [3:0]        vvvv_n_i,
    input  logic [7:0]        opc_i,
    input  logic [7:0]        modrm_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              fault_o,
    output logic [MASK_W-1:0] res_o,
    output logic [MASK_W-1:0] rd_data_o
);
    logic                       legal;
    wid_e                       wid;
    logic [IDX_W-1:0]           src1, src2, dst;
    logic [MASK_W-1:0]          a_val, b_val;
    logic [NUM_REGS*MASK_W-1:0] file_flat;

    mask_andn_decode #(.IDX_W(IDX_W)) u_dec (
        .valid_i (valid_i),
        .len_i   (len_i),
        .pfx_i   (pfx_i),
        .w_i     (w_i),
        .vvvv_n_i(vvvv_n_i),
        .opc_i   (opc_i),
        .modrm_i (modrm_i),
        .legal_o (legal),
        .fault_o (fault_o),
        .wid_o   (wid),
        .src1_o  (src1),
        .src2_o  (src2),
        .dst_o   (dst)
    );

    mask_andn_regfile #(.MASK_W(MASK_W), .NUM_REGS(NUM_REGS), .SEED(SEED)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (legal),
        .waddr_i(dst),
        .wdata_i(res_o),
        .ra1_i  (src1),
        .ra2_i  (src2),
        .ra3_i  (rd_idx_i),
        .rd1_o  (a_val),
        .rd2_o  (b_val),
        .rd3_o  (rd_data_o),
        .all_o  (file_flat)
    );

    mask_andn_alu #(.MASK_W(MASK_W)) u_alu (
        .a_i  (a_val),
        .b_i  (b_val),
        .wid_i(wid),
        .res_o(res_o)
    );
endmodule

// File: rtl/mask_andn_chk.sv
// Checker: temporal properties of the AND-NOT unit, bound to the top.
module mask_andn_chk #(
    parameter int MASK_W   = 64,
    parameter int NUM_REGS = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       valid_i,
    input logic                       len_i,
    input logic [1:0]                 pfx_i,
    input logic                       w_i,
    input logic                       spec_top_i,
    input logic [7:0]                 opc_i,
    input logic [7:0]                 modrm_i,
    input logic                       fault_o,
    input logic [MASK_W-1:0]          res_o,
    input logic [NUM_REGS*MASK_W-1:0] file_i
);
    logic              last_we;
    logic [2:0]        last_dst;
    logic [MASK_W-1:0] last_res;
    logic [MASK_W-1:0] dst_now;

    // Remember the previous cycle's write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_we  <= 1'b0;
            last_dst <= '0;
            last_res <= '0;
        end else begin
            last_we  <= valid_i && !fault_o;
            last_dst <= modrm_i[5:3];
            last_res <= res_o;
        end
    end

    // Current contents of the remembered destination.
    always_comb dst_now = file_i[32'(last_dst) * MASK_W +: MASK_W];

    AST_FAULT_KEEPS_FILE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> $stable(file_i));                                          // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> !fault_o);                                                // R8
    AST_IDLE_KEEPS_FILE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(file_i));                                         // R8
    AST_MEM_FORM_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && modrm_i[7:6] != 2'b11) |-> fault_o);                       // R6
    AST_BAD_FIELD_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (!len_i || opc_i != 8'h42 || pfx_i[1] || !spec_top_i)) |-> fault_o); // R7
    AST_W16_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!w_i && pfx_i == 2'b00) |-> (res_o[MASK_W-1:16] == '0));              // R5
    AST_W8_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!w_i && pfx_i == 2'b01) |-> (res_o[MASK_W-1:8] == '0));               // R5
    AST_W32_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (w_i && pfx_i == 2'b01) |-> (res_o[MASK_W-1:32] == '0));               // R5
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        last_we |-> (dst_now == last_res));                                    // R9
endmodule

bind mask_andn_unit mask_andn_chk #(.MASK_W(MASK_W), .NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .len_i     (len_i),
    .pfx_i     (pfx_i),
    .w_i       (w_i),
    .spec_top_i(vvvv_n_i[3]),
    .opc_i     (opc_i),
    .modrm_i   (modrm_i),
    .fault_o   (fault_o),
    .res_o     (res_o),
    .file_i    (file_flat)
);

// File: tb/tb_mask_andn_unit.sv
`timescale 1ns/1ps
module tb_mask_andn_unit;
    localparam logic [63:0] SEED = 64'hF0E1_D2C3_B4A5_9687;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0, len_i = 1'b0, w_i = 1'b0;
    logic [1:0]  pfx_i = '0;
    logic [3:0]  vvvv_n_i = '0;
    logic [7:0]  opc_i = '0, modrm_i = '0;
    logic [2:0]  rd_idx_i = '0;
    logic        fault_o;
    logic [63:0] res_o, rd_data_o;

    always #10 clk = ~clk;   // 50 MHz

    mask_andn_unit #(.SEED(SEED)) dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .len_i(len_i),
        .pfx_i(pfx_i), .w_i(w_i), .vvvv_n_i(vvvv_n_i), .opc_i(opc_i),
        .modrm_i(modrm_i), .rd_idx_i(rd_idx_i), .fault_o(fault_o),
        .res_o(res_o), .rd_data_o(rd_data_o)
    );

    typedef struct {
        logic        fault;
        logic        cmp_res;
        logic [63:0] res;
        logic [63:0] rd;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    logic [63:0] model [8];
    int          n_cmp = 0, n_bad = 0;
    bit          ended = 0;

    function automatic logic [63:0] rotl(input logic [63:0] x, input int s);
        return (s == 0) ? x : ((x << s) | (x >> (64 - s)));
    endfunction

    task automatic report;
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Driver: applies one cycle of inputs and pushes the expected outputs.
    task automatic step(input logic v, input logic l, input logic [1:0] p, input logic w,
                        input logic [2:0] s1, input logic vtop, input logic [7:0] opc,
                        input logic [1:0] md, input logic [2:0] dst, input logic [2:0] s2,
                        input logic [2:0] ri, input string tag);
        item_t       it;
        logic        legal;
        int          n;
        logic [63:0] wm;
        @(negedge clk);
        valid_i = v; len_i = l; pfx_i = p; w_i = w;
        vvvv_n_i = {vtop, ~s1}; opc_i = opc; modrm_i = {md, dst, s2}; rd_idx_i = ri;
        legal = v && l && !p[1] && vtop && (opc == 8'h42) && (md == 2'b11);
        case ({w, p[0]})
            2'b00: n = 16;
            2'b01: n = 8;
            2'b10: n = 64;
            default: n = 32;
        endcase
        wm = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
        it.fault   = v && !legal;
        it.cmp_res = legal;
        it.res     = (~model[s1] & model[s2]) & wm;
        it.rd      = model[ri];
        it.tag     = tag;
        sb_q.push_back(it);
        if (legal) model[dst] = it.res;
    endtask

    task automatic idle_read(input logic [2:0] ri, input string tag);
        step(1'b0, 1'b1, 2'b00, 1'b0, 3'd0, 1'b1, 8'h42, 2'b11, 3'd0, 3'd0, ri, tag);
    endtask

    task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per cycle and compares the outputs.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                cmp(it.tag, "fault", {63'd0, fault_o}, {63'd0, it.fault});
                if (it.cmp_res) cmp(it.tag, "res", res_o, it.res);
                cmp(it.tag, "rd", rd_data_o, it.rd);
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    // Stimulus.
    initial begin
        for (int i = 0; i < 8; i++) model[i] = rotl(SEED, 8 * i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R10: reset contents, observed with valid low (R8: no fault)
        for (int i = 0; i < 8; i++) idle_read(3'(i), "R1_R10_R8");

        // R2 R3 R4 R5: each width, then read back destination (R9)
        step(1, 1, 2'b00, 0, 3'd1, 1, 8'h42, 2'b11, 3'd4, 3'd2, 3'd4, "R3_R4_w16");
        idle_read(3'd4, "R9_R5_w16");
        step(1, 1, 2'b01, 0, 3'd3, 1, 8'h42, 2'b11, 3'd5, 3'd6, 3'd5, "R3_R4_w8");
        idle_read(3'd5, "R9_R5_w8");
        step(1, 1, 2'b00, 1, 3'd7, 1, 8'h42, 2'b11, 3'd6, 3'd0, 3'd6, "R2_R3_w64");
        idle_read(3'd6, "R9_w64");
        step(1, 1, 2'b01, 1, 3'd2, 1, 8'h42, 2'b11, 3'd7, 3'd1, 3'd7, "R3_R4_w32");
        idle_read(3'd7, "R9_R5_w32");

        // R9: destination equals source, back-to-back dependent ops
        step(1, 1, 2'b00, 1, 3'd0, 1, 8'h42, 2'b11, 3'd0, 3'd3, 3'd0, "R9_dst_src1");
        step(1, 1, 2'b00, 1, 3'd2, 1, 8'h42, 2'b11, 3'd1, 3'd1, 3'd0, "R9_dst_src2");
        step(1, 1, 2'b00, 1, 3'd1, 1, 8'h42, 2'b11, 3'd2, 3'd0, 3'd1, "R9_chain");
        idle_read(3'd2, "R9_chain_read");
        step(1, 1, 2'b00, 1, 3'd5, 1, 8'h42, 2'b11, 3'd5, 3'd5, 3'd5, "R4_self");
        idle_read(3'd5, "R4_self_read");

        // R6: memory forms fault and leave the destination intact
        step(1, 1, 2'b00, 1, 3'd3, 1, 8'h42, 2'b10, 3'd3, 3'd4, 3'd3, "R6_mod10");
        step(1, 1, 2'b00, 1, 3'd3, 1, 8'h42, 2'b00, 3'd3, 3'd4, 3'd3, "R6_mod00");
        idle_read(3'd3, "R6_no_write");

        // R7: other illegal fields
        step(1, 0, 2'b00, 0, 3'd1, 1, 8'h42, 2'b11, 3'd3, 3'd2, 3'd3, "R7_len0");
        step(1, 1, 2'b00, 0, 3'd1, 1, 8'h41, 2'b11, 3'd3, 3'd2, 3'd3, "R7_opc");
        step(1, 1, 2'b10, 0, 3'd1, 1, 8'h42, 2'b11, 3'd3, 3'd2, 3'd3, "R7_pfxF3");
        step(1, 1, 2'b11, 1, 3'd1, 1, 8'h42, 2'b11, 3'd3, 3'd2, 3'd3, "R7_pfxF2");
        step(1, 1, 2'b00, 0, 3'd1, 0, 8'h42, 2'b11, 3'd3, 3'd2, 3'd3, "R7_vtop");
        idle_read(3'd3, "R7_no_write");

        // R8: legal fields with valid low do nothing
        step(0, 1, 2'b00, 1, 3'd6, 1, 8'h42, 2'b11, 3'd3, 3'd7, 3'd3, "R8_idle");
        idle_read(3'd3, "R8_no_write");

        // Final sweep of the whole file
        for (int i = 0; i < 8; i++) idle_read(3'(i), "R10_sweep");

        @(negedge clk);
        valid_i = 1'b0;
        wait (sb_q.size() == 0);
        repeat (2) @(negedge clk);
        report();
    end
endmodule